// File: doc/BRIEF.md
# 16-bit Single-Cycle Processor Core

This block is a small 16-bit processor that retires one instruction on every clock edge. Each cycle it reads a 16-bit word from its instruction store and splits it into four nibbles. It reads two registers and forms a sum in a single adder. It then writes the result back to the register file or to the data store. The adder's second operand may be a register or a sign-extended 4-bit immediate. Three separate decode outputs control the datapath. The first picks which field names the destination register. The second picks whether write-back data comes from the adder or from the data store. The third picks the adder's second operand. Because these selects are independent, an add-immediate can use the same immediate path as a load while still writing back the adder result.

Both stores are internal word-addressed arrays. A preload port writes them, normally while reset is held. An observation port reads any register and any data word combinationally, so the surrounding logic can inspect the machine after it stops. A halt instruction freezes the program counter and raises a status output. The only exit from the halted state is reset.

Top module: `cpu16_core`

## Requirements
- R1: The instruction word is split into opcode [15:12], s [11:8], t [7:4] and low field [3:0]. Opcode 4'h2 writes R[d] = R[s] + R[t], with d taken from the low field and the sum wrapping modulo 2^16.
- R2: Opcode 4'h0 loads a word: R[t] = Mem[R[s] + sext(low field)].
- R3: Opcode 4'h1 stores a word: Mem[R[s] + sext(low field)] = R[t], and no register is written.
- R4: Opcode 4'hD adds a constant: R[t] = R[s] + sext(low field). For example, R0 plus the constant 4'hF yields 16'hFFFF.
- R5: R0 always reads as zero, and any write aimed at R0 is discarded.
- R6: Opcode 4'hF halts the core. `halted` rises and `pc` keeps the address of the halt word. No register or data word changes afterwards until reset.
- R7: While `rst_n` is low at a clock edge, `pc` becomes 0, `halted` becomes 0 and every register becomes 0. Memory contents are kept.
- R8: Each non-halt instruction advances `pc` by exactly 1 on its edge. An opcode outside {0,1,2,D,F} changes nothing except `pc`.
- R9: Address sums wrap modulo 2^16. The data store is indexed by the sum modulo its depth.
- R10: A preload write (`prog_we`) goes to the data store when `prog_dmem` is 1 and to the instruction store otherwise. `obs_reg_val` and `obs_mem_val` show the selected register and data word combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| prog_we | input | 1 | Preload write strobe |
| prog_dmem | input | 1 | Preload target: 1 selects the data store, 0 the instruction store |
| prog_addr | input | 16 | Preload word address |
| prog_wdata | input | 16 | Preload word |
| obs_reg_sel | input | 4 | Register to observe |
| obs_reg_val | output | 16 | Value of the observed register |
| obs_mem_addr | input | 16 | Data word address to observe |
| obs_mem_val | output | 16 | Value of the observed data word |
| pc | output | 16 | Program counter |
| halted | output | 1 | High once a halt has retired |

## Verification
The assertions assume three things about the inputs. First, `rst_n` is low for at least one edge before the program starts. Second, the preload port is idle while the core is running, so a store and a preload never compete for the data store's single write port. Third, the store depths are powers of two. The stimulus fills both stores only while reset is held. It releases reset at a falling edge and leaves `prog_we` low from then on. It touches only the observation inputs once the core is running.

// File: rtl/cpu16_pkg.sv
// cpu16_pkg: shared constants, opcode values and the decoder's control bundle.
// Assumes a fixed 16-bit word with four 4-bit instruction fields.
package cpu16_pkg;

    localparam int XLEN = 16;
    localparam int FLD  = 4;

    typedef enum logic [3:0] {
        OP_LOAD  = 4'h0,
        OP_STORE = 4'h1,
        OP_ADD   = 4'h2,
        OP_ADDI  = 4'hD,
        OP_HALT  = 4'hF
    } opcode_e;

    typedef struct packed {
        logic dst_is_t;   // write address from t field (else low field)
        logic wb_is_mem;  // write-back data from data store (else adder)
        logic opb_is_imm; // adder operand B is the immediate (else R[t])
        logic reg_we;
        logic mem_we;
        logic halt;
    } ctl_t;

endpackage

// File: rtl/cpu16_decode.sv
// cpu16_decode: maps the opcode nibble to the three datapath selects and the
// write enables. Assumes any opcode not listed acts as a no-op.
module cpu16_decode
    import cpu16_pkg::*;
(
    input  logic [3:0] opcode,
    output ctl_t       ctl
);

    // Decode table: one control bundle per opcode.
    always_comb begin
        ctl = '0;
        case (opcode)
            OP_LOAD:  begin ctl.dst_is_t = 1'b1; ctl.wb_is_mem = 1'b1;
                            ctl.opb_is_imm = 1'b1; ctl.reg_we = 1'b1; end
            OP_STORE: begin ctl.opb_is_imm = 1'b1; ctl.mem_we = 1'b1; end
            OP_ADD:   begin ctl.reg_we = 1'b1; end
            OP_ADDI:  begin ctl.dst_is_t = 1'b1; ctl.opb_is_imm = 1'b1;
                            ctl.reg_we = 1'b1; end
            OP_HALT:  begin ctl.halt = 1'b1; end
            default:  ctl = '0;
        endcase
    end

    // A store never also writes a register (R3).
    always_comb begin
        p_store_no_regwrite_r3: assert (!(ctl.mem_we && ctl.reg_we));
    end

endmodule

// File: rtl/cpu16_regfile.sv
// cpu16_regfile: NREG x W register file with NRD combinational read ports and
// one synchronous write port. Entry 0 reads as zero and ignores writes.
// Reset clears all entries.
module cpu16_regfile #(
    parameter int W    = 16,
    parameter int NREG = 16,
    parameter int NRD  = 3
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic [NRD-1:0][$clog2(NREG)-1:0]      raddr,
    output logic [NRD-1:0][W-1:0]                 rdata,
    input  logic                                  we,
    input  logic [$clog2(NREG)-1:0]               waddr,
    input  logic [W-1:0]                          wdata
);

    logic [W-1:0] regs [NREG];

    // Read ports: zero register forced, others straight from storage.
    for (genvar i = 0; i < NRD; i++) begin : g_rd
        assign rdata[i] = (raddr[i] == '0) ? '0 : regs[raddr[i]];
    end

    // Write port: clear on reset, otherwise store unless aimed at entry 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < NREG; k++) regs[k] <= '0;
        end else if (we && waddr != '0) begin
            regs[waddr] <= wdata;
        end
    end

    p_write_lands_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (we && waddr != '0) |=> regs[$past(waddr)] == $past(wdata));

    p_r0_discard_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (we && waddr == '0) |=> regs[0] == '0);

endmodule

// File: rtl/cpu16_mem.sv
// cpu16_mem: word store with one synchronous write port and NRD combinational
// read ports. Addresses are AW bits and are reduced modulo DEPTH, which is
// assumed to be a power of two. Contents are not reset. rst_n only gates the
// assertion.
module cpu16_mem #(
    parameter int W     = 16,
    parameter int AW    = 16,
    parameter int DEPTH = 64,
    parameter int NRD   = 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [AW-1:0]            waddr,
    input  logic [W-1:0]             wdata,
    input  logic [NRD-1:0][AW-1:0]   raddr,
    output logic [NRD-1:0][W-1:0]    rdata
);

    localparam int IW = $clog2(DEPTH);

    logic [W-1:0]  store [DEPTH];
    logic [IW-1:0] widx;

    assign widx = IW'(waddr % AW'(DEPTH));

    // Read ports: wrap each address into the array.
    for (genvar i = 0; i < NRD; i++) begin : g_rd
        logic [IW-1:0] ridx;
        assign ridx     = IW'(raddr[i] % AW'(DEPTH));
        assign rdata[i] = store[ridx];
    end

    // Write port: one word per edge.
    always_ff @(posedge clk) begin
        if (we) store[widx] <= wdata;
    end

    p_mem_write_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> store[$past(widx)] == $past(wdata));

endmodule

// File: rtl/cpu16_core.sv
// cpu16_core: single-cycle 16-bit core. Per edge: fetch imem[pc], decode,
// read R[s]/R[t], add, then write back or store. Assumes the preload port is
// idle while running and that reset is held before the first instruction.
module cpu16_core
    import cpu16_pkg::*;
#(
    parameter int IMEM_DEPTH = 64,
    parameter int DMEM_DEPTH = 64,
    parameter int NREG       = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             prog_we,
    input  logic             prog_dmem,
    input  logic [XLEN-1:0]  prog_addr,
    input  logic [XLEN-1:0]  prog_wdata,
    input  logic [3:0]       obs_reg_sel,
    output logic [XLEN-1:0]  obs_reg_val,
    input  logic [XLEN-1:0]  obs_mem_addr,
    output logic [XLEN-1:0]  obs_mem_val,
    output logic [XLEN-1:0]  pc,
    output logic             halted
);

    localparam int RAW = $clog2(NREG);

    logic [XLEN-1:0]            instr;
    logic [3:0]                 f_op, f_s, f_t, f_low;
    ctl_t                       ctl;
    logic                       run;
    logic [XLEN-1:0]            imm, rs_val, rt_val, opb, sum, wb_data;
    logic [2:0][RAW-1:0]        rf_raddr;
    logic [2:0][XLEN-1:0]       rf_rdata;
    logic [RAW-1:0]             rf_waddr;
    logic                       dm_prog, dm_we;
    logic [XLEN-1:0]            dm_waddr, dm_wdata;
    logic [1:0][XLEN-1:0]       dm_raddr, dm_rdata;
    logic [0:0][XLEN-1:0]       im_raddr, im_rdata;

    // Fetch and field split.
    assign im_raddr[0] = pc;
    assign instr       = im_rdata[0];
    assign f_op        = instr[15:12];
    assign f_s         = instr[11:8];
    assign f_t         = instr[7:4];
    assign f_low       = instr[3:0];
    assign run         = rst_n && !halted;

    cpu16_decode u_dec (.opcode(f_op), .ctl(ctl));

    // Operand fetch, immediate extension and the single adder.
    assign rf_raddr[0] = RAW'(f_s);
    assign rf_raddr[1] = RAW'(f_t);
    assign rf_raddr[2] = RAW'(obs_reg_sel);
    assign rs_val      = rf_rdata[0];
    assign rt_val      = rf_rdata[1];
    assign obs_reg_val = rf_rdata[2];
    assign imm         = {{(XLEN-FLD){f_low[FLD-1]}}, f_low};
    assign opb         = ctl.opb_is_imm ? imm : rt_val;
    assign sum         = rs_val + opb;

    // Write-back selection.
    assign rf_waddr = ctl.dst_is_t ? RAW'(f_t) : RAW'(f_low);
    assign wb_data  = ctl.wb_is_mem ? dm_rdata[0] : sum;

    cpu16_regfile #(.W(XLEN), .NREG(NREG), .NRD(3)) u_rf (
        .clk(clk), .rst_n(rst_n),
        .raddr(rf_raddr), .rdata(rf_rdata),
        .we(run && ctl.reg_we), .waddr(rf_waddr), .wdata(wb_data)
    );

    // Data store: preload has the write port when strobed, else the core.
    assign dm_prog     = prog_we && prog_dmem;
    assign dm_we       = dm_prog || (run && ctl.mem_we);
    assign dm_waddr    = dm_prog ? prog_addr  : sum;
    assign dm_wdata    = dm_prog ? prog_wdata : rt_val;
    assign dm_raddr[0] = sum;
    assign dm_raddr[1] = obs_mem_addr;
    assign obs_mem_val = dm_rdata[1];

    cpu16_mem #(.W(XLEN), .AW(XLEN), .DEPTH(DMEM_DEPTH), .NRD(2)) u_dmem (
        .clk(clk), .rst_n(rst_n), .we(dm_we), .waddr(dm_waddr),
        .wdata(dm_wdata), .raddr(dm_raddr), .rdata(dm_rdata)
    );

    cpu16_mem #(.W(XLEN), .AW(XLEN), .DEPTH(IMEM_DEPTH), .NRD(1)) u_imem (
        .clk(clk), .rst_n(rst_n), .we(prog_we && !prog_dmem),
        .waddr(prog_addr), .wdata(prog_wdata),
        .raddr(im_raddr), .rdata(im_rdata)
    );

    // Sequencer: program counter and halt flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc     <= '0;
            halted <= 1'b0;
        end else if (!halted) begin
            if (ctl.halt) halted <= 1'b1;
            else          pc     <= pc + 1'b1;
        end
    end

    p_halt_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

    p_pc_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> $stable(pc));

    p_pc_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!halted && f_op != OP_HALT) |=> (pc == $past(pc) + 1'b1) && !halted);

endmodule

// File: tb/tb_cpu16_core.sv
`timescale 1ns/1ps
// tb_cpu16_core: preloads a program, runs to halt, walks an expected-state
// table, then runs directed checks for halt timing, freeze and reset.
module tb_cpu16_core;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        prog_we = 1'b0, prog_dmem = 1'b0;
    logic [15:0] prog_addr = '0, prog_wdata = '0;
    logic [3:0]  obs_reg_sel = '0;
    logic [15:0] obs_reg_val, obs_mem_addr = '0, obs_mem_val, pc;
    logic        halted;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    cpu16_core dut (.*);

    // Program: {op,s,t,low}
    localparam logic [15:0] PROG [16] = '{
        16'hD011,  // 0 ADDI R0,1 -> R1 = 1               R4
        16'h2115,  // 1 ADD R1+R1 -> R5 = 2               R1
        16'h2156,  // 2 ADD R1+R5 -> R6 = 3               R1
        16'hD654,  // 3 ADDI R6,4 -> R5 = 7               R4
        16'hD02F,  // 4 ADDI R0,-1 -> R2 = FFFF           R4
        16'h1152,  // 5 ST R5 -> M[R1+2]=M[3]=7           R3
        16'h0172,  // 6 LD R7 <- M[3] = 7                 R2
        16'h068F,  // 7 LD R8 <- M[R6-1]=M[2]=ABCD        R2
        16'hD005,  // 8 ADDI into R0, discarded           R5
        16'h2029,  // 9 ADD R0+R2 -> R9 = FFFF            R5
        16'h1284,  // 10 ST R8 -> M[FFFF+4]=M[3]          R9
        16'h5123,  // 11 undefined opcode, no effect      R8
        16'h222A,  // 12 ADD R2+R2 -> R10 = FFFE          R1
        16'hF000,  // 13 HALT                             R6
        16'hD0B7,  // 14 must not run: R11 stays 0        R6
        16'h1010   // 15 must not run: M[0] stays 5555    R6
    };

    // Expected state: {is_mem, addr[7:0], value[15:0], req[7:0]}
    localparam logic [32:0] EXPECT [15] = '{
        {1'b0, 8'd1,  16'h0001, 8'd4},   // R4
        {1'b0, 8'd5,  16'h0007, 8'd4},   // R4 worked example
        {1'b0, 8'd6,  16'h0003, 8'd1},   // R1 worked example
        {1'b0, 8'd2,  16'hFFFF, 8'd4},   // R4 R0 + -1
        {1'b0, 8'd7,  16'h0007, 8'd2},   // R2
        {1'b0, 8'd8,  16'hABCD, 8'd2},   // R2 negative offset
        {1'b0, 8'd0,  16'h0000, 8'd5},   // R5
        {1'b0, 8'd9,  16'hFFFF, 8'd5},   // R5 R0 reads zero
        {1'b0, 8'd3,  16'h0000, 8'd8},   // R8 undefined opcode
        {1'b0, 8'd10, 16'hFFFE, 8'd1},   // R1 wrap of sum
        {1'b0, 8'd11, 16'h0000, 8'd6},   // R6 after halt
        {1'b1, 8'd3,  16'hABCD, 8'd9},   // R9 wrapped store address
        {1'b1, 8'd2,  16'hABCD, 8'd3},   // R3 untouched neighbour
        {1'b1, 8'd0,  16'h5555, 8'd6},   // R6 store after halt blocked
        {1'b1, 8'd4,  16'h0000, 8'd3}    // R3 no stray write
    };

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    task automatic preload(input logic to_dmem, input logic [15:0] a, input logic [15:0] d);
        @(negedge clk);
        prog_we = 1'b1; prog_dmem = to_dmem; prog_addr = a; prog_wdata = d;
        @(negedge clk);
        prog_we = 1'b0;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        int cyc;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R7 pc in reset", pc, 16'h0000);
        check("R7 halted in reset", {15'd0, halted}, 16'h0000);
        obs_reg_sel = 4'd5; #0.1;
        check("R7 register cleared", obs_reg_val, 16'h0000);

        for (int i = 0; i < 16; i++) preload(1'b0, 16'(i), PROG[i]);
        for (int i = 0; i < 8; i++) preload(1'b1, 16'(i), 16'h0000);
        preload(1'b1, 16'd0, 16'h5555);
        preload(1'b1, 16'd2, 16'hABCD);
        obs_mem_addr = 16'd2; #0.1;
        check("R10 preload readback", obs_mem_val, 16'hABCD);
        obs_mem_addr = 16'h0042; #0.1;   // 0x42 mod 64 = 2
        check("R9 observe index wraps", obs_mem_val, 16'hABCD);

        @(negedge clk);
        rst_n = 1'b1;
        cyc = 0;
        while (!halted && cyc < 100) begin
            @(posedge clk); cyc++; #1;
        end
        check("R8 edges to halt", 16'(cyc), 16'd14);
        check("R6 pc at halt", pc, 16'd13);

        foreach (EXPECT[i]) begin
            if (EXPECT[i][32]) begin
                obs_mem_addr = {8'd0, EXPECT[i][31:24]}; #0.1;
                check($sformatf("R%0d mem[%0d]", EXPECT[i][7:0], EXPECT[i][31:24]),
                      obs_mem_val, EXPECT[i][23:8]);
            end else begin
                obs_reg_sel = EXPECT[i][27:24]; #0.1;
                check($sformatf("R%0d reg[%0d]", EXPECT[i][7:0], EXPECT[i][31:24]),
                      obs_reg_val, EXPECT[i][23:8]);
            end
        end

        repeat (5) @(posedge clk);
        #1;
        check("R6 pc frozen", pc, 16'd13);
        check("R6 halted held", {15'd0, halted}, 16'h0001);

        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk); #1;
        check("R7 pc after reset", pc, 16'h0000);
        check("R7 halted after reset", {15'd0, halted}, 16'h0000);
        obs_reg_sel = 4'd5; #0.1;
        check("R7 R5 cleared", obs_reg_val, 16'h0000);
        obs_mem_addr = 16'd3; #0.1;
        check("R7 memory kept", obs_mem_val, 16'hABCD);

        done = 1;
        finish_run();
    end

endmodule